// File: doc/BRIEF.md
# PWM Time-Base Clock Control Register

This block holds one 32-bit control and status word for the PWM time base and derives the PWM clock enable from it. A source field picks one of two incoming clock enables: the peripheral bus enable or an auxiliary generator enable. A power-of-two divider then counts the chosen enables and emits a single-cycle PWM clock enable pulse. Software reaches the word through a simple write strobe with address and a combinational read port decoded against a parameterised address.

A lock bit guards the source and divide fields. While it is set, writes to those fields are dropped, and the lock bit itself stays writable. The word also carries two flags for a high-resolution edge-placement unit that lives outside this block: a ready flag that mirrors an input, and a sticky error flag that a hardware pulse sets and a software write of zero clears. Both flags read as zero while the high-resolution feature is disabled or absent. The error flag is not lost when the feature is disabled. A source change waits until the PWM-on input is low, so the time base never switches clocks under a running generator.

Top module: `pwm_clkctl`

## Requirements
- R1: After reset the register reads 32'h0000_0004: divide code 0, source 0, lock 0, error 0, and ready 0 while the ready input is low.
- R2: Divide code in bits [5:4]: 0 gives one pwm_ce pulse per 2 selected enables, 1 per 4, 2 per 8, 3 per 16. The pulse coincides with the Nth selected enable and lasts one cycle.
- R3: Lock is bit 8. While it reads 1, a write leaves bits [5:4] and bit 0 unchanged. Every write loads bit 8 from the write data, so it can be cleared as well as set.
- R4: Error flag is bit 14. A high-resolution error pulse with the feature enabled sets it. A write with bit 14 at 0 clears it. A write with bit 14 at 1 leaves it as it is. A set and a clear in the same cycle leave it set.
- R5: While hr_en is low, bits 15 and 14 read 0. The stored error survives and reads back once hr_en returns high.
- R6: Ready flag is bit 15. It reads as hr_ready while hr_en is high, and writes to it have no effect.
- R7: Bit 2 always reads 1. All bits other than 0, 2, 5:4, 8, 14 and 15 read 0, whatever was written.
- R8: Source select is bit 0: 0 counts bus_ce and 1 counts aux_ce. A new selection takes effect only on a clock edge where pwm_on is low. Until then the previous source keeps feeding the divider.
- R9: When the divide code changes, the divider restarts from zero. The first pulse after the change comes on the Nth selected enable counted after the cycle that followed the change.
- R10: Only a write with reg_addr equal to REG_ADDR alters the register. A read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from reg_addr |
| bus_ce | input | 1 | Peripheral bus clock enable |
| aux_ce | input | 1 | Auxiliary clock generator enable |
| pwm_on | input | 1 | High while any PWM generator runs |
| hr_en | input | 1 | High-resolution feature enable |
| hr_ready | input | 1 | Ready status from the high-resolution unit |
| hr_err | input | 1 | Error pulse from the high-resolution unit |
| pwm_ce | output | 1 | Divided PWM clock enable pulse |

## Verification
The bench builds the block with its defaults: an 8-bit address with the register at 8'h20, a two-bit divide code, and the high-resolution flags present. The two-bit code brings all four ratios within reach, including the 16-count wrap of the divider's widest counter. Having the flags present lets the sticky error be set, masked, restored and cleared. The bench feeds bus_ce and aux_ce with different gap patterns, so a wrong source selection or a missed restart shows up as a shifted pulse.

// File: rtl/pwm_clkctl_pkg.sv
// Shared field positions of the PWM clock control word.
// Assumes a fixed 32-bit word; the positions are the software-visible layout.
package pwm_clkctl_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 2;
    localparam int B_SRC   = 0;
    localparam int B_RSV   = 2;
    localparam int B_DIVLO = 4;
    localparam int B_LOCK  = 8;
    localparam int B_ERR   = 14;
    localparam int B_RDY   = 15;
endpackage

// File: rtl/pwm_clkctl_regs.sv
// Register storage: lock-guarded configuration, sticky error flag, read image.
// Assumes wr_hit is already address-qualified; the lock test uses the pre-write lock.
module pwm_clkctl_regs
    import pwm_clkctl_pkg::*;
#(
    parameter bit HR_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              hr_en,
    input  logic              hr_ready,
    input  logic              hr_err,
    output logic              lock,
    output logic [DIV_W-1:0]  div_code,
    output logic              src_req,
    output logic              err_q,
    output logic [WORD_W-1:0] image
);
    logic rdy_vis;

    // Configuration fields: lock always writable, the rest only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock     <= 1'b0;
            div_code <= '0;
            src_req  <= 1'b0;
        end else if (wr_hit) begin
            lock <= wr_data[B_LOCK];
            if (!lock) begin
                div_code <= wr_data[B_DIVLO +: DIV_W];
                src_req  <= wr_data[B_SRC];
            end
        end
    end

    generate
        if (HR_PRESENT) begin : g_hr
            // Sticky error: hardware set wins over a software write of zero.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    err_q <= 1'b0;
                end else if (hr_en && hr_err) begin
                    err_q <= 1'b1;
                end else if (wr_hit && !wr_data[B_ERR]) begin
                    err_q <= 1'b0;
                end
            end
            assign rdy_vis = hr_ready & hr_en;
        end else begin : g_no_hr
            assign err_q   = 1'b0;
            assign rdy_vis = 1'b0;
        end
    endgenerate

    // Read image: unlisted bits zero, reserved bit fixed at one.
    always_comb begin
        image                  = '0;
        image[B_SRC]           = src_req;
        image[B_RSV]           = 1'b1;
        image[B_DIVLO +: DIV_W] = div_code;
        image[B_LOCK]          = lock;
        image[B_ERR]           = err_q & hr_en;
        image[B_RDY]           = rdy_vis;
    end
endmodule

// File: rtl/pwm_clkctl_srcsel.sv
// Clock-enable source mux whose selection only follows the request while PWM is off.
// Assumes both enables are synchronous to clk.
module pwm_clkctl_srcsel (
    input  logic clk,
    input  logic rst_n,
    input  logic src_req,
    input  logic pwm_on,
    input  logic bus_ce,
    input  logic aux_ce,
    output logic src_act,
    output logic sel_ce
);
    // Active source: adopt the requested one only when no generator runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_act <= 1'b0;
        end else if (!pwm_on) begin
            src_act <= src_req;
        end
    end

    // Pass the enable of the active source.
    always_comb sel_ce = src_act ? aux_ce : bus_ce;
endmodule

// File: rtl/pwm_clkctl_div.sv
// Power-of-two enable divider: ratio 2^(code+1), restarts when the code changes.
// Assumes ce is a single-cycle enable; pulse is combinational from ce.
module pwm_clkctl_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [DIV_W-1:0] div_code,
    output logic             pulse
);
    localparam int CNT_W = 2 ** DIV_W;

    logic [DIV_W-1:0] code_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             changed;

    // Terminal count: low (code+1) bits set.
    always_comb begin
        last = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i <= int'(div_code)) last[i] = 1'b1;
        end
    end

    always_comb changed = (div_code != code_q);
    always_comb pulse   = ce && !changed && (cnt == last);

    // Counter: restart on code change, else count enables and wrap at terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            cnt    <= '0;
        end else begin
            code_q <= div_code;
            if (changed) begin
                cnt <= '0;
            end else if (ce) begin
                cnt <= (cnt == last) ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_clkctl.sv
// Top: address decode, control register, source select and PWM enable divider.
// Assumes single-cycle writes and a combinational read at reg_addr.
module pwm_clkctl
    import pwm_clkctl_pkg::*;
#(
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h20,
    parameter bit               HR_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              bus_ce,
    input  logic              aux_ce,
    input  logic              pwm_on,
    input  logic              hr_en,
    input  logic              hr_ready,
    input  logic              hr_err,
    output logic              pwm_ce
);
    logic              rd_hit;
    logic              wr_hit;
    logic              lock;
    logic [DIV_W-1:0]  div_code;
    logic              src_req;
    logic              src_act;
    logic              sel_ce;
    logic              err_q;
    logic [WORD_W-1:0] image;

    // Address decode for both directions.
    always_comb rd_hit = (reg_addr == REG_ADDR);
    always_comb wr_hit = wr_en && rd_hit;
    always_comb rd_data = rd_hit ? image : '0;

    pwm_clkctl_regs #(.HR_PRESENT(HR_PRESENT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(wr_data),
        .hr_en(hr_en), .hr_ready(hr_ready), .hr_err(hr_err),
        .lock(lock), .div_code(div_code), .src_req(src_req),
        .err_q(err_q), .image(image)
    );

    pwm_clkctl_srcsel u_src (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .pwm_on(pwm_on),
        .bus_ce(bus_ce), .aux_ce(aux_ce), .src_act(src_act), .sel_ce(sel_ce)
    );

    pwm_clkctl_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .ce(sel_ce), .div_code(div_code), .pulse(pwm_ce)
    );
endmodule

// File: rtl/pwm_clkctl_chk.sv
// Property checker for pwm_clkctl, attached with bind below.
// Assumes it sees the top's internal state through the bind connections.
module pwm_clkctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_hit,
    input logic [31:0] wr_data,
    input logic        lock,
    input logic [1:0]  div_code,
    input logic        src_req,
    input logic        src_act,
    input logic        err_q,
    input logic        pwm_on,
    input logic        pwm_ce,
    input logic        sel_ce,
    input logic        rd_hit,
    input logic [31:0] rd_data,
    input logic        hr_en
);
    a_r3_lock_guards: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_hit) |=> ($stable(div_code) && $stable(src_req)));

    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !(wr_hit && !wr_data[14])) |=> err_q);

    a_r5_flags_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !hr_en) |-> (rd_data[15:14] == 2'b00));

    a_r8_src_held: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_on |=> $stable(src_act));

    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_ce |=> !pwm_ce);

    a_r2_pulse_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_ce |-> sel_ce);

    a_r10_no_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (rd_data == 32'h0));
endmodule

bind pwm_clkctl pwm_clkctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_data(wr_data),
    .lock(lock), .div_code(div_code), .src_req(src_req), .src_act(src_act),
    .err_q(err_q), .pwm_on(pwm_on), .pwm_ce(pwm_ce), .sel_ce(sel_ce),
    .rd_hit(rd_hit), .rd_data(rd_data), .hr_en(hr_en)
);

// File: tb/pwm_clkctl_tb.sv
// Bench: behavioural reference model compared on every falling edge,
// plus directed checks tagged by requirement.
module pwm_clkctl_tb;
    localparam logic [7:0] RA = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = RA;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        bus_ce = 1'b0, aux_ce = 1'b0, pwm_on = 1'b0;
    logic        hr_en = 1'b0, hr_ready = 1'b0, hr_err = 1'b0;
    logic        pwm_ce;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick = 0;
    bit done = 1'b0;

    // reference state
    int m_div = 0, m_divq = 0, m_cnt = 0;
    bit m_lock = 0, m_src = 0, m_act = 0, m_err = 0;

    always #10 clk = ~clk;

    pwm_clkctl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .bus_ce(bus_ce), .aux_ce(aux_ce),
        .pwm_on(pwm_on), .hr_en(hr_en), .hr_ready(hr_ready), .hr_err(hr_err),
        .pwm_ce(pwm_ce)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Enable patterns: bus has a gap every fifth cycle, aux fires every third.
    always @(posedge clk) begin
        #1;
        tick++;
        bus_ce = (tick % 5) != 4;
        aux_ce = (tick % 3) == 0;
    end

    // Reference model update at the clock edge.
    always @(posedge clk) begin
        bit ce, hit;
        if (!rst_n) begin
            m_div = 0; m_divq = 0; m_cnt = 0;
            m_lock = 0; m_src = 0; m_act = 0; m_err = 0;
        end else begin
            hit = wr_en && (reg_addr == RA);
            ce  = m_act ? aux_ce : bus_ce;
            if (m_div != m_divq) m_cnt = 0;
            else if (ce) m_cnt = (m_cnt == (2 << m_div) - 1) ? 0 : m_cnt + 1;
            m_divq = m_div;
            if (!pwm_on) m_act = m_src;
            if (hr_en && hr_err) m_err = 1;
            else if (hit && !wr_data[14]) m_err = 0;
            if (hit) begin
                if (!m_lock) begin
                    m_div = int'(wr_data[5:4]);
                    m_src = wr_data[0];
                end
                m_lock = wr_data[8];
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        logic [31:0] e;
        bit ece;
        if (rst_n) begin
            ece = (m_act ? aux_ce : bus_ce) && (m_div == m_divq) && (m_cnt == (2 << m_div) - 1);
            e = '0;
            if (reg_addr == RA) begin
                e[0] = m_src; e[2] = 1'b1; e[5:4] = 2'(m_div); e[8] = m_lock;
                e[14] = m_err & hr_en; e[15] = hr_ready & hr_en;
            end
            chk(pwm_ce == ece, "R2/R8/R9 pwm_ce", {31'd0, pwm_ce}, {31'd0, ece});
            chk(rd_data[15] == e[15], "R6 ready bit", rd_data, e);
            chk(rd_data[14] == e[14], "R4/R5 error bit", rd_data, e);
            chk(rd_data[8] == e[8] && rd_data[5:4] == e[5:4], "R3 lock/div", rd_data, e);
            chk(rd_data[0] == e[0], "R8 source bit", rd_data, e);
            chk(rd_data == e, "R7/R10 read word", rd_data, e);
        end
    end

    // Watchdog: a hang counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            errors++;
            $display("FAIL watchdog (all R) act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; reg_addr = RA;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic rd_expect(input logic [31:0] mask, input logic [31:0] exp, input string tag);
        @(negedge clk);
        chk((rd_data & mask) == exp, tag, rd_data & mask, exp);
    endtask

    initial begin
        int pulses;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        rd_expect(32'hFFFF_FFFF, 32'h0000_0004, "R1 reset word");

        // R2: every ratio on the bus enable
        for (int c = 0; c < 4; c++) begin
            wr(RA, 32'h4 | (c << 4));
            idle(70);
        end
        // R2: pulse count over a window at divide 16
        wr(RA, 32'h34);
        idle(2);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (pwm_ce) pulses++;
        end
        chk(pulses >= 9 && pulses <= 11, "R2 divide-16 pulse count", pulses, 10);

        // R9: change code mid-count
        wr(RA, 32'h14);
        idle(3);
        wr(RA, 32'h24);
        idle(30);

        // R3: lock blocks div and source, lock itself writable
        wr(RA, 32'h114);
        wr(RA, 32'h135);
        rd_expect(32'h0000_0131, 32'h0000_0110, "R3 locked fields held");
        wr(RA, 32'h031);
        rd_expect(32'h0000_0131, 32'h0000_0010, "R3 unlock keeps fields");
        wr(RA, 32'h021);
        rd_expect(32'h0000_0131, 32'h0000_0021, "R3 write after unlock");

        // R8: source change held while PWM runs
        wr(RA, 32'h004);
        idle(5);
        pwm_on = 1'b1;
        wr(RA, 32'h005);
        idle(40);
        pwm_on = 1'b0;
        idle(40);
        wr(RA, 32'h014);
        idle(30);

        // R4/R5: sticky error
        hr_en = 1'b1;
        idle(1);
        hr_err = 1'b1; idle(1); hr_err = 1'b0;
        rd_expect(32'h0000_4000, 32'h0000_4000, "R4 error set by pulse");
        wr(RA, 32'h4014);
        rd_expect(32'h0000_4000, 32'h0000_4000, "R4 write one keeps error");
        hr_en = 1'b0;
        rd_expect(32'h0000_C000, 32'h0, "R5 flags masked when disabled");
        idle(3);
        hr_en = 1'b1;
        rd_expect(32'h0000_4000, 32'h0000_4000, "R5 error survives disable");
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = 32'h0014; hr_err = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0; hr_err = 1'b0;
        rd_expect(32'h0000_4000, 32'h0000_4000, "R4 set beats clear");
        wr(RA, 32'h0014);
        rd_expect(32'h0000_4000, 32'h0, "R4 write zero clears");

        // R6: ready mirror, write ignored
        hr_ready = 1'b1;
        wr(RA, 32'h0014);
        rd_expect(32'h0000_8000, 32'h0000_8000, "R6 ready visible");
        hr_ready = 1'b0;
        wr(RA, 32'h8014);
        rd_expect(32'h0000_8000, 32'h0, "R6 write cannot set ready");

        // R10: foreign address
        wr(8'h21, 32'h0035);
        rd_expect(32'h0000_0031, 32'h0000_0010, "R10 foreign write ignored");
        @(posedge clk); #2 reg_addr = 8'h10;
        rd_expect(32'hFFFF_FFFF, 32'h0, "R10 foreign read zero");
        #2 reg_addr = RA;

        // R7: all-ones write
        wr(RA, 32'hFFFF_FFFF);
        rd_expect(32'hFFFF_3FFF, 32'h0000_0135, "R7 unused bits zero, bit 2 one");
        wr(RA, 32'h0000_0000);
        rd_expect(32'h0000_0004, 32'h0000_0004, "R7 reserved stays one");
        idle(40);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule